// File: doc/BRIEF.md
# Two-Channel DMA Transfer Engine

This block copies words from one memory region to another without processor involvement. It has two independent channels. Each channel has four software-visible registers: control, source base, destination base and word count. Once a channel is enabled, it reads one word from its current source address and writes that word to its current destination address. It repeats this until the programmed number of words has moved. All traffic goes through one shared synchronous memory port that uses a request/acknowledge handshake.

Each side of a transfer can independently hold its address constant, step it up by four bytes, or step it down by four bytes. This covers three cases: draining a single port into a buffer, filling one sink from a buffer, and copying blocks in reverse order. A channel either runs back-to-back from a software start, or moves one word for each rising edge on its own external request line. When a transfer completes, the enable bit clears itself and a sticky done flag is set. The done flag can raise the shared interrupt output.

Top module: `dma2ch_engine`

## Requirements
- R1: After reset every register of both channels reads zero, `irq` is low and `mem_req` is low.
- R2: Register map. Channel c uses bank base 0x20*c. Within a bank, control is at +0x00, source base at +0x04, destination base at +0x08 and word count at +0x0C. Writes to one channel's bank leave the other bank unchanged.
- R3: Control bit 0 is the enable bit. When the last word of a transfer has been written, hardware clears it and sets the sticky done flag in control bit 16. The base and count registers keep their programmed values.
- R4: With mode 00 in control bits [3:2], setting the enable bit copies count words back-to-back. Each word is one read of the source followed by one write of the read data to the destination.
- R5: Source and destination each have a fixed bit and a down bit. Source uses fixed bit 4 and down bit 5; destination uses fixed bit 6 and down bit 7. A fixed address stays at its base value. Otherwise the address moves by 4 after each word: up when the down bit is 0, down when it is 1.
- R6: `irq` is the OR over channels of done AND the interrupt-enable bit (control bit 8). With bit 8 at 0, a completed channel leaves `irq` low.
- R7: Writing 1 to control bit 16 clears done. Writing 0 to it leaves done unchanged.
- R8: Modes 10 and 11 are reserved. Writing enable with a reserved mode leaves the enable bit at 0 and issues no memory access.
- R9: In mode 01 the channel moves exactly one word for each rising edge of its `xreq` bit. A request held high for several cycles counts once. With no edge, no access is made.
- R10: When both channels are ready to start a word in the same cycle, channel 0 is served first.
- R11: Enabling a channel with a count of zero completes it at once, with no memory access.
- R12: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values.
- R13: While a channel's enable bit is 1, writes to its control register change nothing except the done clear. A memory request is only issued while some channel is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |
| xreq | input | 2 | Per-channel external request, edge-counted in mode 01 |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` on a read |
| mem_ack | input | 1 | Memory access completes this cycle |
| irq | output | 1 | Interrupt, OR of enabled done flags |

## Verification
A corrupted working address or a wrong step shows up on `mem_addr` during the very next word, which is at most three cycles after the fault when memory does not stall. It also lands as a misplaced word in the destination buffer. A remaining-count error shows up either as the enable bit clearing too early, with words missing at the tail, or as extra writes past the buffer end. A lost or duplicated external request changes the number of memory accesses that follow a pulse. Sequencing faults in the done or enable logic show up on `irq` and in the control readback in the cycle after the last write.

// File: rtl/dma2ch_pkg.sv
// Shared constants and types for the two-channel DMA engine.
// Assumes a 32-bit register bus and word-sized (4-byte) transfers.
package dma2ch_pkg;

    // Control register bit positions
    localparam int CB_EN       = 0;
    localparam int CB_MODE_LO  = 2;
    localparam int CB_MODE_HI  = 3;
    localparam int CB_SRC_FIX  = 4;
    localparam int CB_SRC_DEC  = 5;
    localparam int CB_DST_FIX  = 6;
    localparam int CB_DST_DEC  = 7;
    localparam int CB_IEN      = 8;
    localparam int CB_DONE     = 16;

    // Start modes
    localparam logic [1:0] MODE_SW  = 2'b00;
    localparam logic [1:0] MODE_EXT = 2'b01;

    // Bytes per word step
    localparam int WORD_BYTES = 4;

    // Per-channel static configuration
    typedef struct packed {
        logic [1:0] mode;
        logic       src_fix;
        logic       src_dec;
        logic       dst_fix;
        logic       dst_dec;
        logic       irq_en;
    } chan_cfg_t;

    // Shared memory port sequencer states
    typedef enum logic [1:0] {
        P_IDLE = 2'd0,
        P_RD   = 2'd1,
        P_WR   = 2'd2
    } port_st_t;

endpackage

// File: rtl/dma2ch_regs.sv
// Register file for all channels: control, source base, destination base
// and word count per channel. Produces a one-cycle start pulse when enable
// is written with a legal mode. Locks control while a channel runs. Holds
// the sticky done flags and forms the interrupt.
// Assumes AW <= 32 and bank stride 0x20 (RAW-5 bank bits >= clog2(NCH)).
module dma2ch_regs
    import dma2ch_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = 32,
    parameter int CW  = 16,
    parameter int RAW = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_wr,
    input  logic [RAW-1:0]           cfg_addr,
    input  logic [31:0]              cfg_wdata,
    output logic [31:0]              cfg_rdata,
    input  logic [NCH-1:0]           fin,
    output logic [NCH-1:0]           en_o,
    output logic [NCH-1:0]           start_o,
    output logic [NCH-1:0]           done_o,
    output chan_cfg_t [NCH-1:0]      cfg_o,
    output logic [NCH-1:0][AW-1:0]   src_base_o,
    output logic [NCH-1:0][AW-1:0]   dst_base_o,
    output logic [NCH-1:0][CW-1:0]   cnt_o,
    output logic                     irq
);

    localparam int BW = RAW - 5;

    logic [BW-1:0]          bank;
    logic [2:0]             reg_sel;
    logic [NCH-1:0][31:0]   ctrl_word;
    logic [NCH-1:0]         ien_vec;
    logic                   unused_addr;

    assign bank        = cfg_addr[RAW-1:5];
    assign reg_sel     = cfg_addr[4:2];
    assign unused_addr = ^cfg_addr[1:0];

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic       hit, wr_ctl, wr_src, wr_dst, wr_cnt;
        logic       en_q, done_q;
        chan_cfg_t  cfg_q;
        logic [AW-1:0] src_q, dst_q;
        logic [CW-1:0] cnt_q;

        assign hit    = cfg_wr && (bank == BW'(i));
        assign wr_ctl = hit && (reg_sel == 3'd0);
        assign wr_src = hit && (reg_sel == 3'd1);
        assign wr_dst = hit && (reg_sel == 3'd2);
        assign wr_cnt = hit && (reg_sel == 3'd3);

        // start only from idle, with enable set and a non-reserved mode
        assign start_o[i] = wr_ctl && !en_q && cfg_wdata[CB_EN]
                            && !cfg_wdata[CB_MODE_HI];

        // control, done and base register updates for one channel
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q   <= 1'b0;
                done_q <= 1'b0;
                cfg_q  <= '0;
                src_q  <= '0;
                dst_q  <= '0;
                cnt_q  <= '0;
            end else begin
                if (wr_ctl && cfg_wdata[CB_DONE]) begin
                    done_q <= 1'b0;
                end
                if (wr_ctl && !en_q) begin
                    cfg_q.mode    <= cfg_wdata[CB_MODE_HI:CB_MODE_LO];
                    cfg_q.src_fix <= cfg_wdata[CB_SRC_FIX];
                    cfg_q.src_dec <= cfg_wdata[CB_SRC_DEC];
                    cfg_q.dst_fix <= cfg_wdata[CB_DST_FIX];
                    cfg_q.dst_dec <= cfg_wdata[CB_DST_DEC];
                    cfg_q.irq_en  <= cfg_wdata[CB_IEN];
                    en_q          <= start_o[i];
                end
                if (fin[i]) begin
                    en_q   <= 1'b0;
                    done_q <= 1'b1;
                end
                if (wr_src) begin
                    src_q <= cfg_wdata[AW-1:0];
                end
                if (wr_dst) begin
                    dst_q <= cfg_wdata[AW-1:0];
                end
                if (wr_cnt) begin
                    cnt_q <= cfg_wdata[CW-1:0];
                end
            end
        end

        assign ctrl_word[i] = {15'd0, done_q, 7'd0, cfg_q.irq_en,
                               cfg_q.dst_dec, cfg_q.dst_fix,
                               cfg_q.src_dec, cfg_q.src_fix,
                               cfg_q.mode, 1'b0, en_q};
        assign en_o[i]       = en_q;
        assign done_o[i]     = done_q;
        assign cfg_o[i]      = cfg_q;
        assign src_base_o[i] = src_q;
        assign dst_base_o[i] = dst_q;
        assign cnt_o[i]      = cnt_q;
        assign ien_vec[i]    = cfg_q.irq_en;
    end

    // read multiplexer over banks and registers
    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (bank == BW'(i)) begin
                case (reg_sel)
                    3'd0:    cfg_rdata = ctrl_word[i];
                    3'd1:    cfg_rdata = 32'(src_base_o[i]);
                    3'd2:    cfg_rdata = 32'(dst_base_o[i]);
                    3'd3:    cfg_rdata = 32'(cnt_o[i]);
                    default: cfg_rdata = '0;
                endcase
            end
        end
    end

    assign irq = |(done_o & ien_vec);

endmodule

// File: rtl/dma2ch_chan.sv
// One channel sequencer. Holds the working source and destination
// addresses and the remaining word count, loaded on the start pulse.
// Steps them after every completed word. Counts external request edges,
// raises ready while words remain, and raises fin once none remain.
// Assumes the port reports busy for the whole of a word in flight.
module dma2ch_chan
    import dma2ch_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          en,
    input  chan_cfg_t     cfg,
    input  logic [AW-1:0] src_base,
    input  logic [AW-1:0] dst_base,
    input  logic [CW-1:0] cnt_base,
    input  logic          xreq,
    input  logic          word_done,
    input  logic          busy,
    output logic          rdy,
    output logic          fin,
    output logic [AW-1:0] src_addr,
    output logic [AW-1:0] dst_addr
);

    logic [CW-1:0] rem;
    logic          pend;
    logic          xreq_q;
    logic          xrise;
    logic          unused_ien;

    assign unused_ien = cfg.irq_en;
    assign xrise      = xreq && !xreq_q;

    // next address for one side: hold, up one word or down one word
    function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a,
                                                input logic fix,
                                                input logic dec);
        if (fix) begin
            return a;
        end else if (dec) begin
            return a - AW'(WORD_BYTES);
        end else begin
            return a + AW'(WORD_BYTES);
        end
    endfunction

    // working address, remaining count and request-edge bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem      <= '0;
            pend     <= 1'b0;
            xreq_q   <= 1'b0;
            src_addr <= '0;
            dst_addr <= '0;
        end else begin
            xreq_q <= xreq;
            if (start) begin
                src_addr <= src_base;
                dst_addr <= dst_base;
                rem      <= cnt_base;
                pend     <= 1'b0;
            end else begin
                if (word_done) begin
                    src_addr <= step_addr(src_addr, cfg.src_fix, cfg.src_dec);
                    dst_addr <= step_addr(dst_addr, cfg.dst_fix, cfg.dst_dec);
                    rem      <= rem - CW'(1);
                    pend     <= 1'b0;
                end
                if (en && (cfg.mode == MODE_EXT) && xrise) begin
                    pend <= 1'b1;
                end
            end
        end
    end

    assign rdy = en && (rem != '0) && !busy && ((cfg.mode == MODE_SW) || pend);
    assign fin = en && (rem == '0) && !busy;

endmodule

// File: rtl/dma2ch_port.sv
// Shared memory port sequencer. In idle it grants the lowest-numbered
// ready channel and latches that channel's addresses. It then performs a
// read, waiting for acknowledge, followed by a write of the read data.
// Request and address stay stable until acknowledged.
module dma2ch_port
    import dma2ch_pkg::*;
#(
    parameter  int NCH = 2,
    parameter  int AW  = 32,
    parameter  int DW  = 32,
    localparam int IW  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NCH-1:0]         rdy,
    input  logic [NCH-1:0][AW-1:0] src_addr,
    input  logic [NCH-1:0][AW-1:0] dst_addr,
    output logic [NCH-1:0]         busy,
    output logic [NCH-1:0]         word_done,
    output logic                   idle_o,
    output logic [IW-1:0]          gnt_o,
    output logic                   mem_req,
    output logic                   mem_we,
    output logic [AW-1:0]          mem_addr,
    output logic [DW-1:0]          mem_wdata,
    input  logic [DW-1:0]          mem_rdata,
    input  logic                   mem_ack
);

    port_st_t      st;
    logic [IW-1:0] gnt;
    logic [IW-1:0] pick;
    logic [AW-1:0] src_l;
    logic [AW-1:0] dst_l;
    logic [DW-1:0] data_q;

    // fixed priority: lowest ready index wins
    always_comb begin
        pick = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (rdy[i]) begin
                pick = IW'(i);
            end
        end
    end

    // grant, read phase and write phase sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= P_IDLE;
            gnt    <= '0;
            src_l  <= '0;
            dst_l  <= '0;
            data_q <= '0;
        end else begin
            case (st)
                P_IDLE: begin
                    if (|rdy) begin
                        gnt   <= pick;
                        src_l <= src_addr[pick];
                        dst_l <= dst_addr[pick];
                        st    <= P_RD;
                    end
                end
                P_RD: begin
                    if (mem_ack) begin
                        data_q <= mem_rdata;
                        st     <= P_WR;
                    end
                end
                P_WR: begin
                    if (mem_ack) begin
                        st <= P_IDLE;
                    end
                end
                default: st <= P_IDLE;
            endcase
        end
    end

    assign mem_req   = (st != P_IDLE);
    assign mem_we    = (st == P_WR);
    assign mem_addr  = (st == P_WR) ? dst_l : src_l;
    assign mem_wdata = data_q;
    assign busy      = (st != P_IDLE) ? (NCH'(1) << gnt) : '0;
    assign word_done = ((st == P_WR) && mem_ack) ? (NCH'(1) << gnt) : '0;
    assign idle_o    = (st == P_IDLE);
    assign gnt_o     = gnt;

endmodule

// File: rtl/dma2ch_engine.sv
// Top level of the two-channel DMA engine. It ties the register file,
// one sequencer per channel and the shared memory port together.
// Assumes a single clock domain and an xreq already synchronous to clk.
module dma2ch_engine
    import dma2ch_pkg::*;
#(
    parameter  int NCH = 2,
    parameter  int AW  = 32,
    parameter  int DW  = 32,
    parameter  int CW  = 16,
    parameter  int RAW = 8,
    localparam int IW  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wr,
    input  logic [RAW-1:0]  cfg_addr,
    input  logic [31:0]     cfg_wdata,
    output logic [31:0]     cfg_rdata,
    input  logic [NCH-1:0]  xreq,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    input  logic            mem_ack,
    output logic            irq
);

    logic [NCH-1:0]          en_bits;
    logic [NCH-1:0]          start;
    logic [NCH-1:0]          done_bits;
    chan_cfg_t [NCH-1:0]     cfg;
    logic [NCH-1:0][AW-1:0]  src_base;
    logic [NCH-1:0][AW-1:0]  dst_base;
    logic [NCH-1:0][CW-1:0]  cnt_base;
    logic [NCH-1:0]          fin;
    logic [NCH-1:0]          chan_rdy;
    logic [NCH-1:0][AW-1:0]  src_addr;
    logic [NCH-1:0][AW-1:0]  dst_addr;
    logic [NCH-1:0]          busy;
    logic [NCH-1:0]          word_done;
    logic [NCH-1:0][1:0]     mode_bits;
    logic                    port_idle;
    logic [IW-1:0]           port_gnt;

    dma2ch_regs #(.NCH(NCH), .AW(AW), .CW(CW), .RAW(RAW)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .fin        (fin),
        .en_o       (en_bits),
        .start_o    (start),
        .done_o     (done_bits),
        .cfg_o      (cfg),
        .src_base_o (src_base),
        .dst_base_o (dst_base),
        .cnt_o      (cnt_base),
        .irq        (irq)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        dma2ch_chan #(.AW(AW), .CW(CW)) chan_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .start     (start[i]),
            .en        (en_bits[i]),
            .cfg       (cfg[i]),
            .src_base  (src_base[i]),
            .dst_base  (dst_base[i]),
            .cnt_base  (cnt_base[i]),
            .xreq      (xreq[i]),
            .word_done (word_done[i]),
            .busy      (busy[i]),
            .rdy       (chan_rdy[i]),
            .fin       (fin[i]),
            .src_addr  (src_addr[i]),
            .dst_addr  (dst_addr[i])
        );
        assign mode_bits[i] = cfg[i].mode;
    end

    dma2ch_port #(.NCH(NCH), .AW(AW), .DW(DW)) port_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rdy       (chan_rdy),
        .src_addr  (src_addr),
        .dst_addr  (dst_addr),
        .busy      (busy),
        .word_done (word_done),
        .idle_o    (port_idle),
        .gnt_o     (port_gnt),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack)
    );

endmodule

// File: rtl/dma2ch_engine_chk.sv
// Protocol and sequencing checks for dma2ch_engine, attached by bind.
// Observes the memory port and the register, sequencer and port handoffs.
module dma2ch_engine_chk #(
    parameter  int NCH = 2,
    parameter  int AW  = 32,
    parameter  int DW  = 32,
    localparam int IW  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 mem_req,
    input logic                 mem_we,
    input logic [AW-1:0]        mem_addr,
    input logic [DW-1:0]        mem_wdata,
    input logic                 mem_ack,
    input logic [NCH-1:0]       en_bits,
    input logic [NCH-1:0]       done_bits,
    input logic [NCH-1:0][1:0]  mode_bits,
    input logic [NCH-1:0]       chan_rdy,
    input logic                 port_idle,
    input logic [IW-1:0]        port_gnt
);

    // R12: an unacknowledged request holds every port field
    a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we)
                                   && $stable(mem_addr) && $stable(mem_wdata)));

    // R13: memory traffic only while some channel is enabled
    a_r13_req_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (en_bits != '0));

    // R10: with both channels ready at an idle port, channel 0 is granted
    a_r10_low_first: assert property (@(posedge clk) disable iff (!rst_n)
        (port_idle && chan_rdy[0] && chan_rdy[1]) |=> (port_gnt == '0));

    // R3: hardware only drops enable at completion, together with done
    a_r3_fall_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_bits[0]) |-> done_bits[0]);

    for (genvar i = 0; i < NCH; i++) begin : g_mode
        // R8: an enabled channel never carries a reserved mode
        a_r8_no_reserved_run: assert property (@(posedge clk) disable iff (!rst_n)
            en_bits[i] |-> !mode_bits[i][1]);
    end

endmodule

bind dma2ch_engine dma2ch_engine_chk #(.NCH(NCH), .AW(AW), .DW(DW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .en_bits   (en_bits),
    .done_bits (done_bits),
    .mode_bits (mode_bits),
    .chan_rdy  (chan_rdy),
    .port_idle (port_idle),
    .port_gnt  (port_gnt)
);

// File: tb/dma2ch_engine_tb_top.sv
// Directed bench for dma2ch_engine: one task per scenario, each self-checking.
module dma2ch_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr;
    logic [7:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic [1:0]  xreq;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        irq;
    logic        stall_en;
    logic        stall;

    int total = 0;
    int bad   = 0;
    int acc   = 0;
    logic [31:0] mem [0:255];

    always #4 clk = ~clk;

    dma2ch_engine dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .xreq(xreq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .irq(irq)
    );

    // memory model: zero-wait or alternating-stall acknowledge
    assign mem_rdata = mem[mem_addr[9:2]];
    assign mem_ack   = mem_req && !stall;

    always @(posedge clk) begin
        if (mem_req && mem_ack) begin
            acc = acc + 1;
            if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
        end
    end

    always @(negedge clk) stall <= stall_en ? ~stall : 1'b0;

    function automatic logic [31:0] pat(int k);
        return 32'hC0DE_0000 | 32'(k);
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        check(act === exp, tag, act, exp);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic init_mem();
        for (int i = 0; i < 256; i++) mem[i] = pat(i);
    endtask

    task automatic wait_off(input int ch, input string tag);
        logic [31:0] v;
        for (int n = 0; n < 3000; n++) begin
            rd(8'(ch * 32), v);
            if (!v[0]) return;
        end
        check(1'b0, {tag, " enable never cleared"}, 32'd1, 32'd0);
    endtask

    task automatic pulse(input int ch, input int len);
        @(negedge clk);
        xreq[ch] = 1'b1;
        repeat (len) @(negedge clk);
        xreq[ch] = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 64; a += 4) begin
            rd(8'(a), v);
            eq("R1 register reset value", v, 32'h0);
        end
        eq("R1 irq after reset", 32'(irq), 32'h0);
        eq("R1 mem_req after reset", 32'(mem_req), 32'h0);
    endtask

    task automatic t_map();
        logic [31:0] v;
        wr(8'h24, 32'h0000_1110);
        wr(8'h28, 32'h0000_2220);
        wr(8'h2C, 32'h0000_0033);
        rd(8'h24, v); eq("R2 ch1 source base readback", v, 32'h1110);
        rd(8'h28, v); eq("R2 ch1 destination base readback", v, 32'h2220);
        rd(8'h2C, v); eq("R2 ch1 count readback", v, 32'h33);
        rd(8'h04, v); eq("R2 ch0 source untouched", v, 32'h0);
        rd(8'h0C, v); eq("R2 ch0 count untouched", v, 32'h0);
    endtask

    task automatic t_sw_copy();
        logic [31:0] v;
        init_mem();
        wr(8'h04, 32'h010); wr(8'h08, 32'h200); wr(8'h0C, 32'd4);
        wr(8'h00, 32'h101);
        wait_off(0, "R4");
        for (int k = 0; k < 4; k++) eq("R4 R5 incrementing copy word", mem[128+k], pat(4+k));
        eq("R4 word past end untouched", mem[132], pat(132));
        rd(8'h00, v); eq("R3 control after completion", v, 32'h0001_0100);
        rd(8'h04, v); eq("R3 source base kept", v, 32'h010);
        rd(8'h0C, v); eq("R3 count kept", v, 32'd4);
        eq("R6 irq with enable bit set", 32'(irq), 32'h1);
        wr(8'h00, 32'h0001_0000);
        rd(8'h00, v); eq("R7 done cleared by writing 1", v, 32'h0);
        eq("R6 irq after clear", 32'(irq), 32'h0);
    endtask

    task automatic t_fix_dec();
        logic [31:0] v;
        init_mem();
        // source fixed, destination down
        wr(8'h04, 32'h020); wr(8'h08, 32'h21C); wr(8'h0C, 32'd3);
        wr(8'h00, 32'h091);
        wait_off(0, "R5a");
        for (int k = 0; k < 3; k++) eq("R5 fixed source into falling dest", mem[135-k], pat(8));
        eq("R5 below dest range untouched", mem[132], pat(132));
        eq("R5 above dest range untouched", mem[136], pat(136));
        wr(8'h00, 32'h0001_0000);
        init_mem();
        // source down, destination fixed, interrupt disabled
        wr(8'h04, 32'h03C); wr(8'h08, 32'h240); wr(8'h0C, 32'd3);
        wr(8'h00, 32'h061);
        wait_off(0, "R5b");
        eq("R5 fixed dest holds last source word", mem[144], pat(13));
        eq("R5 neighbour of fixed dest untouched", mem[145], pat(145));
        eq("R6 irq low with enable bit clear", 32'(irq), 32'h0);
        wr(8'h00, 32'h0000_0000);
        rd(8'h00, v); eq("R7 writing 0 keeps done", v[16], 1'b1);
        wr(8'h00, 32'h0001_0000);
        rd(8'h00, v); eq("R7 done cleared", v, 32'h0);
    endtask

    task automatic t_reserved();
        logic [31:0] v;
        int a0;
        a0 = acc;
        wr(8'h20, 32'h009);
        rd(8'h20, v); eq("R8 mode 10 leaves enable low", 32'(v[0]), 32'h0);
        wr(8'h20, 32'h00D);
        rd(8'h20, v); eq("R8 mode 11 leaves enable low", 32'(v[0]), 32'h0);
        repeat (20) @(negedge clk);
        eq("R8 no memory access", 32'(acc - a0), 32'h0);
        wr(8'h20, 32'h0);
    endtask

    task automatic t_ext();
        logic [31:0] v;
        int a0;
        init_mem();
        wr(8'h24, 32'h080); wr(8'h28, 32'h300); wr(8'h2C, 32'd3);
        a0 = acc;
        wr(8'h20, 32'h105);
        repeat (12) @(negedge clk);
        eq("R9 no access without request edge", 32'(acc - a0), 32'h0);
        pulse(1, 1);
        eq("R9 one word per edge", 32'(acc - a0), 32'h2);
        eq("R9 first word copied", mem[192], pat(32));
        wr(8'h20, 32'h0);
        rd(8'h20, v); eq("R13 control locked while enabled", v, 32'h105);
        pulse(1, 6);
        eq("R9 held request counts once", 32'(acc - a0), 32'h4);
        pulse(1, 1);
        wait_off(1, "R9");
        eq("R9 third word copied", mem[194], pat(34));
        rd(8'h20, v); eq("R3 ch1 control after completion", v, 32'h0001_0104);
        eq("R6 irq from channel 1", 32'(irq), 32'h1);
        wr(8'h20, 32'h0001_0000);
    endtask

    task automatic t_priority();
        logic [31:0] first;
        init_mem();
        wr(8'h04, 32'h000); wr(8'h08, 32'h280); wr(8'h0C, 32'd1);
        wr(8'h24, 32'h040); wr(8'h28, 32'h2C0); wr(8'h2C, 32'd1);
        wr(8'h00, 32'h005);
        wr(8'h20, 32'h005);
        @(negedge clk);
        xreq = 2'b11;
        @(negedge clk);
        xreq = 2'b00;
        first = 32'hFFFF_FFFF;
        for (int n = 0; n < 20; n++) begin
            if (mem_req) begin first = mem_addr; break; end
            @(negedge clk);
        end
        eq("R10 channel 0 served first", first, 32'h000);
        wait_off(0, "R10a");
        wait_off(1, "R10b");
        eq("R10 channel 0 word", mem[160], pat(0));
        eq("R10 channel 1 word", mem[176], pat(16));
        wr(8'h00, 32'h0001_0000);
        wr(8'h20, 32'h0001_0000);
    endtask

    task automatic t_zero();
        logic [31:0] v;
        int a0;
        wr(8'h0C, 32'd0);
        a0 = acc;
        wr(8'h00, 32'h101);
        repeat (4) @(negedge clk);
        rd(8'h00, v); eq("R11 zero count completes", v, 32'h0001_0100);
        eq("R11 no memory access", 32'(acc - a0), 32'h0);
        eq("R11 irq raised", 32'(irq), 32'h1);
        wr(8'h00, 32'h0001_0000);
    endtask

    task automatic t_stall();
        init_mem();
        stall_en = 1'b1;
        wr(8'h04, 32'h100); wr(8'h08, 32'h380); wr(8'h0C, 32'd5);
        wr(8'h00, 32'h001);
        wait_off(0, "R12");
        for (int k = 0; k < 5; k++) eq("R12 copy under stalls", mem[224+k], pat(64+k));
        stall_en = 1'b0;
        wr(8'h00, 32'h0001_0000);
    endtask

    initial begin
        #(8 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        xreq = '0; stall_en = 1'b0;
        init_mem();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_map();
        t_sw_copy();
        t_fix_dec();
        t_reserved();
        t_ext();
        t_priority();
        t_zero();
        t_stall();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule